// File: doc/BRIEF.md
# Interleaved Video Input Demultiplexer

This block sits at the front of a video processing core. It accepts three 13-bit video ports and one 13-bit key port, and it delivers four separated channels to the core: luma, blue-difference chroma, red-difference chroma and key. A static two-bit mode selects how the video ports are read. In the first mode, three independent channels arrive in parallel. In the second, luma arrives on port A and Cb/Cr alternate on port B. In the third, port A carries a full 4:2:2 stream in the order Cb, Y, Cr, Y, and the core runs at half the clock rate.

The chroma phase comes from the sync input. A registered falling edge of sync marks the sample latched with sync low as a Cb sample. The internal phase counter then runs freely and can be realigned by another falling edge at any time. In half-rate mode the block also drives a core clock enable. This enable toggles every clock within the single clock domain, and an align pulse forces it to a known phase. Each split chroma output holds its last value until its next sample arrives. A valid strobe marks the cycles in which the core takes a new sample.

Top module: `vid_demux`

## Requirements
- R1: While rst_n is low, every data output and valid_o are 0. The core enable reads 0 in mode 01 and 1 in the other modes.
- R2: In mode 11, the y, cb and cr outputs equal ports A, B and C latched 3 clocks earlier.
- R3: In mode 10 (bit0=0, bit1=1), y_o equals port A latched 4 clocks earlier.
- R4: In mode 10, port B samples with chroma phase 0 go to cb_o and samples with phase 1 go to cr_o, 4 clocks later. The other chroma output holds its value, so at most one chroma output changes in any cycle.
- R5: In mode 01 (bit0=1, bit1=0), port A samples with phase 0 go to cb_o, phase 2 to cr_o, and phases 1 and 3 to y_o, 5 clocks later. An output not being written holds its value.
- R6: In mode 01, valid_o is high exactly when the sample emerging 5 clocks after input has an odd phase (a luma sample). This makes valid_o high at most every other cycle.
- R7: A sample latched with sync_i low, immediately after a sample latched with sync_i high, gets phase 0 (Cb). Each later sample takes the previous phase plus one, modulo 2 in mode 10 and modulo 4 in mode 01. A fresh falling edge restarts the count at 0 at any point.
- R8: key_o equals port D delayed by the latency of the active mode: 3, 4 or 5 clocks.
- R9: In mode 01, core_en_o inverts on every clock. The exception is that after a clock where align_i is high, core_en_o is 0.
- R10: Mode 00 behaves exactly as mode 11.
- R11: In modes 00, 11 and 10, valid_o and core_en_o stay high after the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Port arrangement: 00/11 parallel, 10 luma plus interleaved chroma, 01 single-port 4:2:2 |
| sync_i | input | 1 | Chroma phase mark; a registered falling edge tags Cb |
| align_i | input | 1 | Forces the half-rate enable phase |
| a_i | input | 13 | Video port A |
| b_i | input | 13 | Video port B |
| c_i | input | 13 | Video port C |
| d_i | input | 13 | Key port |
| y_o | output | 13 | Luma channel to the core |
| cb_o | output | 13 | Blue-difference chroma to the core |
| cr_o | output | 13 | Red-difference chroma to the core |
| key_o | output | 13 | Key channel to the core |
| valid_o | output | 1 | Core sampling strobe |
| core_en_o | output | 1 | Half-rate core clock enable |

## Verification
A sync falling edge can land on the same sample that the free-running phase counter would also tag. It can also land on a sample the counter considers Cr or luma, so the resynchronising edge and the normal phase advance compete in one cycle. The bench first toggles sync on every expected Cb sample, where both sources agree. It then drops a single falling edge on an odd sample, so the mark must win and move Cb and Cr onto the new phase. In half-rate mode, align pulses are also placed so they meet a toggling enable. Every output in every cycle is compared with a model rebuilt in the bench from the input history.

// File: rtl/vdm_pkg.sv
package vdm_pkg;

    typedef enum logic [1:0] {
        MODE_PAR_ALT = 2'b00,
        MODE_SINGLE  = 2'b01,
        MODE_DUAL    = 2'b10,
        MODE_PAR     = 2'b11
    } vdm_mode_e;

    localparam int unsigned TAG_W = 2;

    typedef logic [TAG_W-1:0] vdm_tag_t;

endpackage

// File: rtl/vdm_phase.sv
module vdm_phase
    import vdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       sync_i,
    input  logic       align_i,
    output vdm_tag_t   tag_o,
    output logic       core_en_o
);

    typedef struct packed {
        logic     sync;
        vdm_tag_t tag;
        logic     en;
    } phase_t;

    phase_t   st_d, st_q;
    vdm_tag_t mask;
    logic     fall;

    always_comb begin
        st_d = st_q;
        mask = (mode_i == MODE_SINGLE) ? vdm_tag_t'(3) : vdm_tag_t'(1);
        fall = st_q.sync & ~sync_i;
        st_d.sync = sync_i;
        st_d.tag  = fall ? '0 : ((st_q.tag + vdm_tag_t'(1)) & mask);
        st_d.en   = align_i ? 1'b0 : ~st_q.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= 1'b0;
            st_q.tag  <= '1;
            st_q.en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_o     = st_d.tag;
    assign core_en_o = (mode_i == MODE_SINGLE) ? st_q.en : 1'b1;

endmodule

// File: rtl/vdm_delay.sv
module vdm_delay #(
    parameter int unsigned WID   = 54,
    parameter int unsigned DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WID-1:0]            in_i,
    output logic [DEPTH-1:0][WID-1:0] tap_o
);

    logic [DEPTH-1:0][WID-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = in_i;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_comb begin
            pipe_d[g] = pipe_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign tap_o = pipe_q;

endmodule

// File: rtl/vdm_select.sv
module vdm_select
    import vdm_pkg::*;
#(
    parameter int unsigned DW    = 13,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned WID  = 4 * DW + TAG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_i,
    input  logic [DEPTH-1:0][WID-1:0] tap_i,
    output logic [DW-1:0]             y_o,
    output logic [DW-1:0]             cb_o,
    output logic [DW-1:0]             cr_o,
    output logic [DW-1:0]             key_o,
    output logic                      valid_o
);

    localparam int unsigned TAP_PAR    = 1;
    localparam int unsigned TAP_DUAL   = 2;
    localparam int unsigned TAP_SINGLE = 3;

    typedef struct packed {
        logic [DW-1:0] y;
        logic [DW-1:0] cb;
        logic [DW-1:0] cr;
        logic [DW-1:0] key;
        logic          valid;
    } out_t;

    out_t          o_d, o_q;
    logic [WID-1:0] w;
    logic [DW-1:0]  fa, fb, fc, fd;
    vdm_tag_t       ft;

    always_comb begin
        o_d = o_q;
        case (mode_i)
            MODE_SINGLE: w = tap_i[TAP_SINGLE];
            MODE_DUAL:   w = tap_i[TAP_DUAL];
            default:     w = tap_i[TAP_PAR];
        endcase
        fa = w[DW-1:0];
        fb = w[2*DW-1:DW];
        fc = w[3*DW-1:2*DW];
        fd = w[4*DW-1:3*DW];
        ft = w[WID-1:4*DW];
        o_d.key = fd;
        case (mode_i)
            MODE_SINGLE: begin
                o_d.valid = ft[0];
                case (ft)
                    2'd0:    o_d.cb = fa;
                    2'd2:    o_d.cr = fa;
                    default: o_d.y  = fa;
                endcase
            end
            MODE_DUAL: begin
                o_d.valid = 1'b1;
                o_d.y     = fa;
                if (ft[0]) o_d.cr = fb;
                else       o_d.cb = fb;
            end
            default: begin
                o_d.valid = 1'b1;
                o_d.y     = fa;
                o_d.cb    = fb;
                o_d.cr    = fc;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign y_o     = o_q.y;
    assign cb_o    = o_q.cb;
    assign cr_o    = o_q.cr;
    assign key_o   = o_q.key;
    assign valid_o = o_q.valid;

endmodule

// File: rtl/vid_demux.sv
module vid_demux
    import vdm_pkg::*;
#(
    parameter int unsigned DW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          sync_i,
    input  logic          align_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] c_i,
    input  logic [DW-1:0] d_i,
    output logic [DW-1:0] y_o,
    output logic [DW-1:0] cb_o,
    output logic [DW-1:0] cr_o,
    output logic [DW-1:0] key_o,
    output logic          valid_o,
    output logic          core_en_o
);

    localparam int unsigned MAX_LAT = 5;
    localparam int unsigned DEPTH   = MAX_LAT - 1;
    localparam int unsigned WID     = 4 * DW + TAG_W;

    vdm_tag_t                  tag;
    logic [WID-1:0]            word;
    logic [DEPTH-1:0][WID-1:0] taps;

    vdm_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .sync_i    (sync_i),
        .align_i   (align_i),
        .tag_o     (tag),
        .core_en_o (core_en_o)
    );

    assign word = {tag, d_i, c_i, b_i, a_i};

    vdm_delay #(.WID(WID), .DEPTH(DEPTH)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (word),
        .tap_o (taps)
    );

    vdm_select #(.DW(DW), .DEPTH(DEPTH)) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .tap_i   (taps),
        .y_o     (y_o),
        .cb_o    (cb_o),
        .cr_o    (cr_o),
        .key_o   (key_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/vid_demux_chk.sv
module vid_demux_chk #(
    parameter int unsigned DW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          align_i,
    input logic [DW-1:0] cb_o,
    input logic [DW-1:0] cr_o,
    input logic          valid_o,
    input logic          core_en_o
);

    localparam logic [1:0] M_SINGLE = 2'b01;
    localparam logic [1:0] M_DUAL   = 2'b10;

    p_valid_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_SINGLE && valid_o) |=> (mode_i != M_SINGLE || !valid_o));

    p_chroma_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_DUAL && $stable(mode_i)) |-> ($stable(cb_o) || $stable(cr_o)));

    p_en_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_SINGLE && !align_i) |=> (mode_i != M_SINGLE || core_en_o != $past(core_en_o)));

    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_SINGLE && align_i) |=> (mode_i != M_SINGLE || !core_en_o));

    p_full_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != M_SINGLE) |=> valid_o);

endmodule

bind vid_demux vid_demux_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .align_i   (align_i),
    .cb_o      (cb_o),
    .cr_o      (cr_o),
    .valid_o   (valid_o),
    .core_en_o (core_en_o)
);

// File: tb/vid_demux_tb.sv
`timescale 1ns/1ps
module vid_demux_tb;

    localparam int DW = 13;
    localparam int N  = 120;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'b11;
    logic          sync_i = 1'b0;
    logic          align_i = 1'b0;
    logic [DW-1:0] a_i = '0, b_i = '0, c_i = '0, d_i = '0;
    logic [DW-1:0] y_o, cb_o, cr_o, key_o;
    logic          valid_o, core_en_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int ha [0:N+1];
    int hb [0:N+1];
    int hc [0:N+1];
    int hd [0:N+1];
    int hs [0:N+1];
    int hal[0:N+1];
    int htg[0:N+1];
    int hen[0:N+1];

    always #2.5 clk = ~clk;

    vid_demux #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sync_i(sync_i), .align_i(align_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i), .d_i(d_i),
        .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o), .key_o(key_o),
        .valid_o(valid_o), .core_en_o(core_en_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int gen_sync(input int k);
        return (k == 3 || (k >= 7 && k <= 39 && k % 4 == 3) || k == 56) ? 1 : 0;
    endfunction

    function automatic int gen_align(input int k);
        return (k == 2 || k == 30 || k == 31 || k == 75) ? 1 : 0;
    endfunction

    // latest sample index <= n whose tag matches (sel: 0 Cb, 1 Cr-dual, 2 Cr-single, 3 odd)
    function automatic int last_of(input int n, input int sel);
        for (int k = n; k >= 1; k--) begin
            if (sel == 3 && htg[k] % 2 == 1) return ha[k];
            if (sel == 0 && htg[k] == 0) return -1 - k;
            if (sel == 1 && htg[k] == 1) return -1 - k;
            if (sel == 2 && htg[k] == 2) return -1 - k;
        end
        return -1;
    endfunction

    task automatic drive(input int k, input int md);
        int mask;
        mask = (md == 1) ? 3 : 1;
        ha[k] = (k * 37 + md * 101 + 5) % 8192;
        hb[k] = (k * 53 + md * 29 + 900) % 8192;
        hc[k] = (k * 71 + 3000) % 8192;
        hd[k] = (k * 97 + md * 7 + 11) % 8192;
        hs[k] = gen_sync(k);
        hal[k] = (md == 1) ? gen_align(k) : 0;
        htg[k] = (hs[k-1] == 1 && hs[k] == 0) ? 0 : ((htg[k-1] + 1) & mask);
        a_i = DW'(ha[k]); b_i = DW'(hb[k]); c_i = DW'(hc[k]); d_i = DW'(hd[k]);
        sync_i = hs[k][0]; align_i = hal[k][0];
    endtask

    task automatic run_mode(input int md);
        int lat, n, r, exp_cb, exp_cr, exp_y;
        string rq;
        lat = (md == 1) ? 5 : (md == 2) ? 4 : 3;
        rq  = (md == 0) ? "R10" : "R2";
        rst_n = 1'b0;
        mode_i = md[1:0];
        sync_i = 0; align_i = 0; a_i = '0; b_i = '0; c_i = '0; d_i = '0;
        repeat (3) @(negedge clk);
        chk("R1", "y", int'(y_o), 0);
        chk("R1", "cb", int'(cb_o), 0);
        chk("R1", "cr", int'(cr_o), 0);
        chk("R1", "key", int'(key_o), 0);
        chk("R1", "valid", int'(valid_o), 0);
        chk("R1", "core_en", int'(core_en_o), (md == 1) ? 0 : 1);
        rst_n = 1'b1;
        ha[0] = 0; hb[0] = 0; hc[0] = 0; hd[0] = 0; hs[0] = 0; hal[0] = 0;
        htg[0] = 3; hen[0] = 0;
        drive(1, md);
        for (int m = 1; m <= N; m++) begin
            @(negedge clk);
            hen[m] = hal[m] ? 0 : 1 - hen[m-1];
            if (md == 1) chk("R9", "core_en", int'(core_en_o), hen[m]);
            else         chk("R11", "core_en", int'(core_en_o), 1);
            if (m >= lat) begin
                n = m - lat + 1;
                chk("R8", "key", int'(key_o), hd[n]);
                if (md == 1) begin
                    r = last_of(n, 0); exp_cb = (r == -1) ? 0 : ha[-1 - r];
                    r = last_of(n, 2); exp_cr = (r == -1) ? 0 : ha[-1 - r];
                    r = last_of(n, 3); exp_y  = (r == -1) ? 0 : r;
                    chk("R5", "y", int'(y_o), exp_y);
                    chk("R5/R7", "cb", int'(cb_o), exp_cb);
                    chk("R5/R7", "cr", int'(cr_o), exp_cr);
                    chk("R6", "valid", int'(valid_o), htg[n] % 2);
                end else if (md == 2) begin
                    r = last_of(n, 0); exp_cb = (r == -1) ? 0 : hb[-1 - r];
                    r = last_of(n, 1); exp_cr = (r == -1) ? 0 : hb[-1 - r];
                    chk("R3", "y", int'(y_o), ha[n]);
                    chk("R4/R7", "cb", int'(cb_o), exp_cb);
                    chk("R4/R7", "cr", int'(cr_o), exp_cr);
                    chk("R11", "valid", int'(valid_o), 1);
                end else begin
                    chk(rq, "y", int'(y_o), ha[n]);
                    chk(rq, "cb", int'(cb_o), hb[n]);
                    chk(rq, "cr", int'(cr_o), hc[n]);
                    chk("R11", "valid", int'(valid_o), 1);
                end
            end
            if (m < N) drive(m + 1, md);
        end
    endtask

    initial begin
        run_mode(3);
        run_mode(0);
        run_mode(2);
        run_mode(1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule